// File: doc/BRIEF.md
# Timer Interrupt Flag and Enable Unit

This block holds the event flags and the per-source interrupt enables for a timer that raises three kinds of event: counter overflow, compare match A and compare match B. Single-cycle pulses from the timer core latch into sticky flags. The unit drives one interrupt request per source. A request is raised while the source's flag is set, its enable bit is set, and the global interrupt enable input is high.

Software reaches both registers through a small register port with an address, a write strobe, write data and combinational read data. A flag has two clear paths. Software can write a one to its bit position, or the interrupt controller can pulse that source's acknowledge line when it takes the vector. When a new event arrives in the same cycle as either clear, the event wins, so no occurrence is lost.

Top module: `tirq_unit`

## Requirements
- R1: While `rst` is high at a rising edge, both registers return to 0x00. After reset every read returns 0x00 and `irq_req` is 0.
- R2: A write to address 0 loads the enable register from `bus_wdata[2:0]`. Bit 0 enables overflow, bit 1 enables compare A and bit 2 enables compare B. Reading address 0 returns those bits with bits 7..3 at zero.
- R3: In both registers, bits 7..3 always read as zero, and writing ones to them changes no state.
- R4: An `evt_pulse` bit sets the matching flag at the next rising edge. Bit 0 is overflow, bit 1 is compare A and bit 2 is compare B, in the same positions as in the flag register at address 1.
- R5: Writing address 1 clears every flag whose `bus_wdata` bit is 1. Flags whose `bus_wdata` bit is 0 keep their value.
- R6: A `vec_ack` bit clears the matching flag at the next rising edge. It uses the same bit positions as R4.
- R7: If a set event and any clear, by software write or by acknowledge, reach the same flag in one cycle, the flag is 1 afterwards.
- R8: `irq_req[i]` is high exactly when `glb_ie`, enable bit i and flag bit i are all 1. It is combinational from the registers, so it drops in the cycle after its flag clears.
- R9: Reads have no side effects. Addresses 2 and 3 read as 0x00, and writes to them change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 2 | Register address: 0 enable, 1 flags |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data of the addressed register |
| evt_pulse | input | 3 | Event pulses from the timer core (bit 0 overflow, 1 compare A, 2 compare B) |
| glb_ie | input | 1 | Global interrupt enable |
| vec_ack | input | 3 | Vector-taken acknowledge per source |
| irq_req | output | 3 | Interrupt request per source |

## Verification
The hardest case to reach from the ports is a single edge where a flag receives an event, a software write-one and an acknowledge all at once, or any two of the three. A full sweep over the packed input word (address, strobe, event, acknowledge, global enable and the low data bits plus one reserved bit) is walked in a scrambled order so that each combination meets many different held states of the registers. A directed step also forces the three-way collision on one flag. A bench-side model computes every read value and every request arithmetically.

// File: rtl/tirq_pkg.sv
package tirq_pkg;

    localparam int NUM_SRC = 3;

    typedef enum logic [1:0] {
        SRC_OVF  = 2'd0,
        SRC_CMPA = 2'd1,
        SRC_CMPB = 2'd2
    } src_e;

    typedef logic [NUM_SRC-1:0] src_vec_t;

    typedef struct packed {
        logic     en_wr;
        src_vec_t en_data;
        src_vec_t flag_clr;
        logic     sel_en;
        logic     sel_flag;
    } bus_op_t;

    function automatic logic flag_next(input logic cur, input logic set,
                                       input logic clr);
        if (set)
            return 1'b1;
        else if (clr)
            return 1'b0;
        return cur;
    endfunction

endpackage

// File: rtl/tirq_bus_decode.sv
module tirq_bus_decode
    import tirq_pkg::*;
#(
    parameter int ADDR_W      = 2,
    parameter int REG_W       = 8,
    parameter int ENABLE_ADDR = 0,
    parameter int FLAG_ADDR   = 1
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [REG_W-1:0]  bus_wdata,
    output bus_op_t           op
);
    localparam int RSVD_W = REG_W - NUM_SRC;

    logic hit_en;
    logic hit_flag;
    logic unused_rsvd;

    assign hit_en      = (bus_addr == ADDR_W'(ENABLE_ADDR));
    assign hit_flag    = (bus_addr == ADDR_W'(FLAG_ADDR));
    assign unused_rsvd = ^bus_wdata[REG_W-1 -: RSVD_W];

    always_comb begin
        op          = '0;
        op.sel_en   = hit_en;
        op.sel_flag = hit_flag;
        op.en_wr    = bus_we && hit_en;
        op.en_data  = bus_wdata[NUM_SRC-1:0];
        op.flag_clr = (bus_we && hit_flag) ? bus_wdata[NUM_SRC-1:0] : '0;
    end
endmodule

// File: rtl/tirq_flag_cell.sv
module tirq_flag_cell
    import tirq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic sw_clr_i,
    input  logic ack_clr_i,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= 1'b0;
        else
            q <= flag_next(q, set_i, sw_clr_i | ack_clr_i);
    end
endmodule

// File: rtl/tirq_read_mux.sv
module tirq_read_mux
    import tirq_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  logic             sel_en,
    input  logic             sel_flag,
    input  src_vec_t         en_q,
    input  src_vec_t         flag_q,
    output logic [REG_W-1:0] rdata
);
    localparam int RSVD_W = REG_W - NUM_SRC;

    src_vec_t low;

    always_comb begin
        if (sel_en)
            low = en_q;
        else if (sel_flag)
            low = flag_q;
        else
            low = '0;
    end

    assign rdata = {{RSVD_W{1'b0}}, low};
endmodule

// File: rtl/tirq_unit.sv
module tirq_unit
    import tirq_pkg::*;
#(
    parameter int ADDR_W      = 2,
    parameter int REG_W       = 8,
    parameter int ENABLE_ADDR = 0,
    parameter int FLAG_ADDR   = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_we,
    input  logic [REG_W-1:0]   bus_wdata,
    output logic [REG_W-1:0]   bus_rdata,
    input  logic [NUM_SRC-1:0] evt_pulse,
    input  logic               glb_ie,
    input  logic [NUM_SRC-1:0] vec_ack,
    output logic [NUM_SRC-1:0] irq_req
);
    bus_op_t  op;
    src_vec_t en_q;
    src_vec_t flag_q;

    tirq_bus_decode #(
        .ADDR_W(ADDR_W), .REG_W(REG_W),
        .ENABLE_ADDR(ENABLE_ADDR), .FLAG_ADDR(FLAG_ADDR)
    ) u_dec (
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .bus_wdata(bus_wdata),
        .op       (op)
    );

    always_ff @(posedge clk) begin
        if (rst)
            en_q <= '0;
        else if (op.en_wr)
            en_q <= op.en_data;
    end

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        tirq_flag_cell u_flag (
            .clk      (clk),
            .rst      (rst),
            .set_i    (evt_pulse[s]),
            .sw_clr_i (op.flag_clr[s]),
            .ack_clr_i(vec_ack[s]),
            .q        (flag_q[s])
        );
        assign irq_req[s] = glb_ie & en_q[s] & flag_q[s];
    end

    tirq_read_mux #(.REG_W(REG_W)) u_rd (
        .sel_en  (op.sel_en),
        .sel_flag(op.sel_flag),
        .en_q    (en_q),
        .flag_q  (flag_q),
        .rdata   (bus_rdata)
    );
endmodule

// File: rtl/tirq_unit_chk.sv
module tirq_unit_chk
    import tirq_pkg::*;
#(
    parameter int ADDR_W      = 2,
    parameter int REG_W       = 8,
    parameter int ENABLE_ADDR = 0,
    parameter int FLAG_ADDR   = 1
) (
    input logic               clk,
    input logic               rst,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_we,
    input logic [REG_W-1:0]   bus_wdata,
    input logic [REG_W-1:0]   bus_rdata,
    input logic [NUM_SRC-1:0] evt_pulse,
    input logic               glb_ie,
    input logic [NUM_SRC-1:0] vec_ack,
    input logic [NUM_SRC-1:0] irq_req,
    input logic [NUM_SRC-1:0] en_q,
    input logic [NUM_SRC-1:0] flag_q
);
    logic flag_wr;
    logic en_wr;
    assign flag_wr = bus_we && (bus_addr == ADDR_W'(FLAG_ADDR));
    assign en_wr   = bus_we && (bus_addr == ADDR_W'(ENABLE_ADDR));

    p_rst_clear_r1: assert property (@(posedge clk)
        rst |=> (en_q == '0 && flag_q == '0));

    p_en_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !en_wr |=> $stable(en_q));

    p_rsvd_zero_r3: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[REG_W-1:NUM_SRC] == '0);

    p_set_r4: assert property (@(posedge clk) disable iff (rst)
        (evt_pulse != '0) |=> ((flag_q & $past(evt_pulse)) == $past(evt_pulse)));

    p_sw_clear_r5: assert property (@(posedge clk) disable iff (rst)
        flag_wr |=> ((flag_q & $past(bus_wdata[NUM_SRC-1:0] & ~evt_pulse)) == '0));

    p_ack_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (vec_ack != '0) |=> ((flag_q & $past(vec_ack & ~evt_pulse)) == '0));

    p_no_spurious_set_r7: assert property (@(posedge clk) disable iff (rst)
        (evt_pulse == '0) |=> ((flag_q & ~$past(flag_q)) == '0));

    p_gie_gate_r8: assert property (@(posedge clk) disable iff (rst)
        !glb_ie |-> (irq_req == '0));

    p_req_needs_both_r8: assert property (@(posedge clk) disable iff (rst)
        (irq_req & ~(flag_q & en_q)) == '0);

    p_flag_idle_r9: assert property (@(posedge clk) disable iff (rst)
        (!flag_wr && evt_pulse == '0 && vec_ack == '0) |=> $stable(flag_q));
endmodule

bind tirq_unit tirq_unit_chk #(
    .ADDR_W(ADDR_W), .REG_W(REG_W),
    .ENABLE_ADDR(ENABLE_ADDR), .FLAG_ADDR(FLAG_ADDR)
) u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_pulse(evt_pulse),
    .glb_ie(glb_ie), .vec_ack(vec_ack), .irq_req(irq_req),
    .en_q(en_q), .flag_q(flag_q)
);

// File: tb/tirq_unit_bench.sv
module tirq_unit_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] bus_addr = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [2:0] evt_pulse = '0;
    logic       glb_ie = 1'b0;
    logic [2:0] vec_ack = '0;
    logic [2:0] irq_req;

    int n_chk  = 0;
    int n_fail = 0;
    logic [2:0] m_en   = '0;
    logic [2:0] m_flag = '0;
    logic       finished = 1'b0;

    always #5 clk = ~clk;

    tirq_unit u_tirq_unit (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_pulse(evt_pulse),
        .glb_ie(glb_ie), .vec_ack(vec_ack), .irq_req(irq_req)
    );

    task automatic check(input string tag, input logic [7:0] act,
                         input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [1:0] a);
        if (a == 2'd0) return {5'b0, m_en};
        if (a == 2'd1) return {5'b0, m_flag};
        return 8'h00;
    endfunction

    // One cycle of stimulus: compare outputs with the model, then advance it.
    task automatic step(input logic [1:0] a, input logic we, input logic [7:0] wd,
                        input logic [2:0] ev, input logic [2:0] ak, input logic gie);
        logic [2:0] clr;
        @(negedge clk);
        bus_addr = a; bus_we = we; bus_wdata = wd;
        evt_pulse = ev; vec_ack = ak; glb_ie = gie;
        #1;
        check(a == 2'd0 ? "R2 read enable" : a == 2'd1 ? "R3 read flags" : "R9 read unmapped",
              bus_rdata, exp_read(a));
        check("R8 request", {5'b0, irq_req}, {5'b0, gie ? (m_en & m_flag) : 3'b000});
        clr = ak | ((we && a == 2'd1) ? wd[2:0] : 3'b000);
        @(posedge clk);
        m_flag = (m_flag & ~clr) | ev;
        if (we && a == 2'd0) m_en = wd[2:0];
    endtask

    task automatic peek(input logic [1:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0; evt_pulse = '0; vec_ack = '0;
        #1;
        check(tag, bus_rdata, exp);
        @(posedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        check("R1 enable after reset", bus_rdata, 8'h00);
        check("R1 request after reset", {5'b0, irq_req}, 8'h00);
        peek(2'd1, 8'h00, "R1 flags after reset");

        step(2'd0, 1'b1, 8'hFF, 3'b000, 3'b000, 1'b1);
        peek(2'd0, 8'h07, "R2 enable write all ones");
        step(2'd1, 1'b1, 8'hF8, 3'b000, 3'b000, 1'b1);
        peek(2'd1, 8'h00, "R3 reserved flag write");
        step(2'd0, 1'b0, 8'h00, 3'b101, 3'b000, 1'b1);
        peek(2'd1, 8'h05, "R4 overflow and compare B set");
        check("R8 requests follow flags", {5'b0, irq_req}, 8'h05);
        step(2'd1, 1'b1, 8'h01, 3'b000, 3'b000, 1'b1);
        peek(2'd1, 8'h04, "R5 write one clears only bit 0");
        step(2'd0, 1'b0, 8'h00, 3'b000, 3'b100, 1'b1);
        peek(2'd1, 8'h00, "R6 acknowledge clears compare B");
        check("R8 request drops after clear", {5'b0, irq_req}, 8'h00);
        step(2'd1, 1'b1, 8'h02, 3'b010, 3'b010, 1'b1);
        peek(2'd1, 8'h02, "R7 set beats both clears");
        step(2'd0, 1'b0, 8'h00, 3'b000, 3'b000, 1'b0);
        check("R8 global enable low", {5'b0, irq_req}, 8'h00);
        step(2'd2, 1'b1, 8'hFF, 3'b000, 3'b000, 1'b1);
        step(2'd3, 1'b1, 8'h00, 3'b000, 3'b000, 1'b1);
        peek(2'd0, 8'h07, "R9 unmapped write keeps enable");
        peek(2'd1, 8'h02, "R9 unmapped write keeps flags");
        peek(2'd1, 8'h02, "R9 second read unchanged");

        // Full sweep of the packed stimulus word in scrambled order.
        for (int i = 0; i < 8192; i++) begin
            logic [12:0] v;
            v = 13'((i * 1237) & 13'h1FFF);
            step(v[1:0], v[2], {v[12], 4'b0, v[5:3]}, v[8:6], v[11:9], v[12] ^ v[0]);
        end

        @(negedge clk); rst = 1'b1; bus_we = 1'b0; evt_pulse = '0; vec_ack = '0;
        @(posedge clk);
        @(negedge clk); rst = 1'b0;
        m_en = '0; m_flag = '0;
        peek(2'd0, 8'h00, "R1 mid-run reset enable");
        peek(2'd1, 8'h00, "R1 mid-run reset flags");

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule